// File: doc/BRIEF.md
# Base Pointer Register Unit

This block keeps the small pointer registers a microcoded processor uses to steer its register-file and memory addressing. It holds a 4-bit region base, a 5-bit memory base-register selector, a 2-bit base-register group index and an 8-bit I/O device address. Microcode loads them through one-hot strobes. The source of a load is either a 16-bit bus word or the 4-bit small-constant field of the current microinstruction.

The register file has 256 words in 16 regions of 16 words each. The block forms the full 8-bit register-file word address by placing the region base above a 4-bit in-region index. It also drives the small-constant field as a zero-extended 16-bit operand. Three loads are special. A relative load picks a memory base selector from the current group index. A combined load sets both the selector and the region base from one bus word. A short load rewrites only the low three bits of the device address.

Top module: `ptr_base_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `rgn_base`, `mem_sel`, `grp_idx` and `dev_addr` become zero on that edge.
- R2: `rf_addr` always equals `{rgn_base, rf_index}`, with the region base in bits [7:4]. A change of `rf_index` shows up without a clock edge.
- R3: `ld_rgn_bus` loads `rgn_base` from `bus_word[3:0]`. `ld_rgn_sc` loads it from `sc_field`.
- R4: `ld_msel_bus` loads `mem_sel` from `bus_word[12:8]`, which are bits 3 to 7 when bit 0 is the most significant bit. `ld_msel_sc` loads `{1'b0, sc_field}`.
- R5: `ld_ptrs_bus` loads `mem_sel` from `bus_word[12:8]` and `rgn_base` from `bus_word[3:0]` on the same edge.
- R6: `ld_grp_sc` loads `grp_idx` from `sc_field[1:0]`.
- R7: `ld_msel_rel` loads `mem_sel` with `{1'b0, grp_idx, sc_field[1:0]}`, using the group index held before that edge.
- R8: `ld_dev_bus` loads `dev_addr` from `bus_word[15:8]`.
- R9: `ld_dev_short` alone replaces `dev_addr[2:0]` with `sc_field[2:0]` and keeps `dev_addr[7:3]`.
- R10: When `ld_dev_bus` and `ld_dev_short` are both high, the full bus load decides `dev_addr`.
- R11: A register with none of its strobes high keeps its value. A strobe for one register leaves the others unchanged.
- R12: `sc_operand` always equals `sc_field` zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_rgn_bus | input | 1 | Region base from bus word |
| ld_rgn_sc | input | 1 | Region base from small constant |
| ld_msel_bus | input | 1 | Memory base selector from bus word |
| ld_msel_sc | input | 1 | Memory base selector from small constant |
| ld_msel_rel | input | 1 | Memory base selector from group index and constant |
| ld_ptrs_bus | input | 1 | Selector and region base together from bus word |
| ld_grp_sc | input | 1 | Group index from small constant |
| ld_dev_bus | input | 1 | Full device address from bus word |
| ld_dev_short | input | 1 | Low three device address bits from constant |
| bus_word | input | 16 | Data bus word |
| sc_field | input | 4 | Small-constant field of the microinstruction |
| rf_index | input | 4 | In-region register index |
| rgn_base | output | 4 | Region base register |
| mem_sel | output | 5 | Memory base-register selector |
| grp_idx | output | 2 | Base-register group index |
| dev_addr | output | 8 | I/O device address |
| rf_addr | output | 8 | Formed register-file word address |
| sc_operand | output | 16 | Small constant as zero-extended operand |

## Verification
The bench uses bus words whose set bits fall outside the selector field, such as 16'hE0FF. A design that numbered the field from the wrong end, or took the wrong slice, would load a non-zero selector there. A relative load is issued after a fresh group load, and again after the group index has changed. A design that ignored the group bits, or swapped them with the constant bits, would give a different selector value. Short device loads are run with constants that both set and clear the low three bits, so a design that also touched the high five bits is caught. A simultaneous full and short load is issued to catch a design that lets the short load win.

// File: rtl/pbu_pkg.sv
package pbu_pkg;

    localparam int WORD_W  = 16;
    localparam int RGN_W   = 4;
    localparam int IDX_W   = 4;
    localparam int SC_W    = 4;
    localparam int GRP_W   = 2;
    localparam int REL_W   = 2;
    localparam int MSEL_W  = 1 + GRP_W + REL_W;
    localparam int DEV_W   = 8;
    localparam int DEV_LO_W = 3;
    localparam int DEV_HI_W = DEV_W - DEV_LO_W;
    localparam int ADDR_W  = RGN_W + IDX_W;
    // selector field spans bits 3..7 counted from the MSB
    localparam int MSEL_LSB = WORD_W - 1 - 7;

    typedef logic [RGN_W-1:0]  rgn_t;
    typedef logic [MSEL_W-1:0] msel_t;
    typedef logic [GRP_W-1:0]  grp_t;
    typedef logic [DEV_W-1:0]  dev_t;
    typedef logic [SC_W-1:0]   sc_t;

    typedef enum logic [1:0] {
        MS_HOLD = 2'd0,
        MS_BUS  = 2'd1,
        MS_SC   = 2'd2,
        MS_REL  = 2'd3
    } msel_src_e;

    typedef struct packed {
        grp_t              grp;
        logic [REL_W-1:0]  k;
    } rel_sel_t;

    function automatic msel_t rel_msel(input rel_sel_t r);
        return {1'b0, r.grp, r.k};
    endfunction

    function automatic dev_t dev_short(input dev_t cur, input logic [DEV_LO_W-1:0] lo);
        return {cur[DEV_W-1 -: DEV_HI_W], lo};
    endfunction

    function automatic logic [WORD_W-1:0] sc_extend(input sc_t sc);
        return {{(WORD_W-SC_W){1'b0}}, sc};
    endfunction

endpackage

// File: rtl/pbu_rgn_reg.sv
module pbu_rgn_reg
    import pbu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld_bus,
    input  logic ld_sc,
    input  rgn_t bus_fld,
    input  sc_t  sc,
    output rgn_t rgn
);
    rgn_t rgn_q;

    always_ff @(posedge clk) begin
        if (rst)         rgn_q <= '0;
        else if (ld_bus) rgn_q <= bus_fld;
        else if (ld_sc)  rgn_q <= rgn_t'(sc);
    end

    assign rgn = rgn_q;
endmodule

// File: rtl/pbu_msel_reg.sv
module pbu_msel_reg
    import pbu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_bus,
    input  logic  ld_sc,
    input  logic  ld_rel,
    input  logic  ld_grp,
    input  msel_t bus_fld,
    input  sc_t   sc,
    output msel_t msel,
    output grp_t  grp
);
    msel_t     msel_q;
    grp_t      grp_q;
    msel_src_e src;
    msel_t     nxt;
    rel_sel_t  rel;

    always_comb begin
        if (ld_rel)      src = MS_REL;
        else if (ld_bus) src = MS_BUS;
        else if (ld_sc)  src = MS_SC;
        else             src = MS_HOLD;
    end

    assign rel = '{grp: grp_q, k: sc[REL_W-1:0]};

    always_comb begin
        unique case (src)
            MS_BUS:  nxt = bus_fld;
            MS_SC:   nxt = msel_t'(sc);
            MS_REL:  nxt = rel_msel(rel);
            default: nxt = msel_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msel_q <= '0;
            grp_q  <= '0;
        end else begin
            msel_q <= nxt;
            if (ld_grp) grp_q <= sc[GRP_W-1:0];
        end
    end

    assign msel = msel_q;
    assign grp  = grp_q;
endmodule

// File: rtl/pbu_dev_reg.sv
module pbu_dev_reg
    import pbu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_bus,
    input  logic                ld_short,
    input  dev_t                bus_fld,
    input  logic [DEV_LO_W-1:0] lo,
    output dev_t                dev
);
    dev_t dev_q;

    always_ff @(posedge clk) begin
        if (rst)           dev_q <= '0;
        else if (ld_bus)   dev_q <= bus_fld;
        else if (ld_short) dev_q <= dev_short(dev_q, lo);
    end

    assign dev = dev_q;
endmodule

// File: rtl/pbu_addr_form.sv
module pbu_addr_form
    import pbu_pkg::*;
(
    input  rgn_t              rgn,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    assign addr = {rgn, idx};
endmodule

// File: rtl/ptr_base_unit.sv
module ptr_base_unit
    import pbu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_rgn_bus,
    input  logic        ld_rgn_sc,
    input  logic        ld_msel_bus,
    input  logic        ld_msel_sc,
    input  logic        ld_msel_rel,
    input  logic        ld_ptrs_bus,
    input  logic        ld_grp_sc,
    input  logic        ld_dev_bus,
    input  logic        ld_dev_short,
    input  logic [15:0] bus_word,
    input  logic [3:0]  sc_field,
    input  logic [3:0]  rf_index,
    output logic [3:0]  rgn_base,
    output logic [4:0]  mem_sel,
    output logic [1:0]  grp_idx,
    output logic [7:0]  dev_addr,
    output logic [7:0]  rf_addr,
    output logic [15:0] sc_operand
);
    rgn_t  bus_rgn;
    msel_t bus_msel;
    dev_t  bus_dev;
    logic  unused_bus_mid;

    assign bus_rgn        = bus_word[RGN_W-1:0];
    assign bus_msel       = bus_word[MSEL_LSB +: MSEL_W];
    assign bus_dev        = bus_word[WORD_W-1 -: DEV_W];
    assign unused_bus_mid = ^bus_word[MSEL_LSB-1:RGN_W];

    pbu_rgn_reg u_rgn (
        .clk    (clk),
        .rst    (rst),
        .ld_bus (ld_rgn_bus | ld_ptrs_bus),
        .ld_sc  (ld_rgn_sc),
        .bus_fld(bus_rgn),
        .sc     (sc_field),
        .rgn    (rgn_base)
    );

    pbu_msel_reg u_msel (
        .clk    (clk),
        .rst    (rst),
        .ld_bus (ld_msel_bus | ld_ptrs_bus),
        .ld_sc  (ld_msel_sc),
        .ld_rel (ld_msel_rel),
        .ld_grp (ld_grp_sc),
        .bus_fld(bus_msel),
        .sc     (sc_field),
        .msel   (mem_sel),
        .grp    (grp_idx)
    );

    pbu_dev_reg u_dev (
        .clk     (clk),
        .rst     (rst),
        .ld_bus  (ld_dev_bus),
        .ld_short(ld_dev_short),
        .bus_fld (bus_dev),
        .lo      (sc_field[DEV_LO_W-1:0]),
        .dev     (dev_addr)
    );

    pbu_addr_form u_addr (
        .rgn (rgn_base),
        .idx (rf_index),
        .addr(rf_addr)
    );

    assign sc_operand = sc_extend(sc_field);
endmodule

// File: rtl/ptr_base_unit_chk.sv
module ptr_base_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        ld_rgn_bus,
    input logic        ld_rgn_sc,
    input logic        ld_msel_bus,
    input logic        ld_msel_sc,
    input logic        ld_msel_rel,
    input logic        ld_ptrs_bus,
    input logic        ld_grp_sc,
    input logic        ld_dev_bus,
    input logic        ld_dev_short,
    input logic [15:0] bus_word,
    input logic [3:0]  sc_field,
    input logic [3:0]  rf_index,
    input logic [3:0]  rgn_base,
    input logic [4:0]  mem_sel,
    input logic [1:0]  grp_idx,
    input logic [7:0]  dev_addr,
    input logic [7:0]  rf_addr,
    input logic [15:0] sc_operand
);
    logic unused_chk;
    assign unused_chk = ^{bus_word[7:4], ld_rgn_sc, ld_msel_sc};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (rgn_base == 4'd0 && mem_sel == 5'd0 && grp_idx == 2'd0 && dev_addr == 8'd0)); // R1

    AST_ADDR_FORMED: assert property (@(posedge clk) disable iff (rst)
        rf_addr[7:4] == rgn_base && rf_addr[3:0] == rf_index); // R2

    AST_RGN_BUS_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld_rgn_bus |=> rgn_base == $past(bus_word[3:0])); // R3

    AST_MSEL_BUS_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld_msel_bus |=> mem_sel == $past(bus_word[12:8])); // R4

    AST_PTRS_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld_ptrs_bus |=> (mem_sel == $past(bus_word[12:8]) && rgn_base == $past(bus_word[3:0]))); // R5

    AST_GRP_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld_grp_sc |=> grp_idx == $past(sc_field[1:0])); // R6

    AST_REL_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld_msel_rel |=> mem_sel == {1'b0, $past(grp_idx), $past(sc_field[1:0])}); // R7

    AST_DEV_BUS_WINS: assert property (@(posedge clk) disable iff (rst)
        ld_dev_bus |=> dev_addr == $past(bus_word[15:8])); // R10

    AST_DEV_SHORT: assert property (@(posedge clk) disable iff (rst)
        (ld_dev_short && !ld_dev_bus) |=>
            (dev_addr[7:3] == $past(dev_addr[7:3]) && dev_addr[2:0] == $past(sc_field[2:0]))); // R9

    AST_DEV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(ld_dev_bus || ld_dev_short) |=> $stable(dev_addr)); // R11

    AST_GRP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld_grp_sc |=> $stable(grp_idx)); // R11

    AST_SC_OPERAND: assert property (@(posedge clk) disable iff (rst)
        sc_operand[15:4] == 12'd0 && sc_operand[3:0] == sc_field); // R12
endmodule

bind ptr_base_unit ptr_base_unit_chk u_chk (.*);

// File: tb/ptr_base_unit_tb.sv
`timescale 1ns/100ps
module ptr_base_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  ld = '0;
    logic [15:0] bus_word = '0;
    logic [3:0]  sc_field = '0;
    logic [3:0]  rf_index = '0;
    logic [3:0]  rgn_base;
    logic [4:0]  mem_sel;
    logic [1:0]  grp_idx;
    logic [7:0]  dev_addr;
    logic [7:0]  rf_addr;
    logic [15:0] sc_operand;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    // strobe order: rgn_bus rgn_sc msel_bus msel_sc msel_rel ptrs grp dev_bus dev_short
    ptr_base_unit u_dut (
        .clk(clk), .rst(rst),
        .ld_rgn_bus(ld[8]), .ld_rgn_sc(ld[7]), .ld_msel_bus(ld[6]),
        .ld_msel_sc(ld[5]), .ld_msel_rel(ld[4]), .ld_ptrs_bus(ld[3]),
        .ld_grp_sc(ld[2]), .ld_dev_bus(ld[1]), .ld_dev_short(ld[0]),
        .bus_word(bus_word), .sc_field(sc_field), .rf_index(rf_index),
        .rgn_base(rgn_base), .mem_sel(mem_sel), .grp_idx(grp_idx),
        .dev_addr(dev_addr), .rf_addr(rf_addr), .sc_operand(sc_operand)
    );

    typedef struct packed {
        logic [8:0]  ld;
        logic [15:0] bus;
        logic [3:0]  sc;
        logic [3:0]  idx;
        logic [3:0]  e_rgn;
        logic [4:0]  e_msel;
        logic [1:0]  e_grp;
        logic [7:0]  e_dev;
        logic [7:0]  e_rf;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{9'b000000100, 16'h0000, 4'hE, 4'h5, 4'h0, 5'h00, 2'd2, 8'h00, 8'h05, 4'd6},  // R6
        '{9'b100000000, 16'hABC7, 4'h0, 4'h3, 4'h7, 5'h00, 2'd2, 8'h00, 8'h73, 4'd3},  // R3
        '{9'b001000000, 16'h1F00, 4'h0, 4'h3, 4'h7, 5'h1F, 2'd2, 8'h00, 8'h73, 4'd4},  // R4
        '{9'b001000000, 16'hE0FF, 4'h0, 4'h3, 4'h7, 5'h00, 2'd2, 8'h00, 8'h73, 4'd4},  // R4
        '{9'b000010000, 16'h0000, 4'hD, 4'h0, 4'h7, 5'h09, 2'd2, 8'h00, 8'h70, 4'd7},  // R7
        '{9'b000001000, 16'h0A5C, 4'h0, 4'hF, 4'hC, 5'h0A, 2'd2, 8'h00, 8'hCF, 4'd5},  // R5
        '{9'b000000010, 16'h5A00, 4'h0, 4'hF, 4'hC, 5'h0A, 2'd2, 8'h5A, 8'hCF, 4'd8},  // R8
        '{9'b000000001, 16'hFFFF, 4'hF, 4'hF, 4'hC, 5'h0A, 2'd2, 8'h5F, 8'hCF, 4'd9},  // R9
        '{9'b000000011, 16'h8100, 4'h0, 4'hF, 4'hC, 5'h0A, 2'd2, 8'h81, 8'hCF, 4'd10}, // R10
        '{9'b010000000, 16'h0000, 4'h3, 4'h0, 4'h3, 5'h0A, 2'd2, 8'h81, 8'h30, 4'd3},  // R3
        '{9'b000100000, 16'h0000, 4'hB, 4'h0, 4'h3, 5'h0B, 2'd2, 8'h81, 8'h30, 4'd4},  // R4
        '{9'b000000000, 16'hFFFF, 4'hF, 4'h0, 4'h3, 5'h0B, 2'd2, 8'h81, 8'h30, 4'd11}, // R11
        '{9'b000000001, 16'h0000, 4'h8, 4'h0, 4'h3, 5'h0B, 2'd2, 8'h80, 8'h30, 4'd9},  // R9
        '{9'b000000100, 16'h0000, 4'h1, 4'h0, 4'h3, 5'h0B, 2'd1, 8'h80, 8'h30, 4'd6},  // R6
        '{9'b000010000, 16'h0000, 4'h2, 4'h0, 4'h3, 5'h06, 2'd1, 8'h80, 8'h30, 4'd7}   // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rf_index = 4'h9;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", {rgn_base, mem_sel, grp_idx, dev_addr}, '0);
        check("R2", rf_addr, 8'h09);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            ld       = VECS[i].ld;
            bus_word = VECS[i].bus;
            sc_field = VECS[i].sc;
            rf_index = VECS[i].idx;
            @(posedge clk);
            #1;
            ld = '0;
            check($sformatf("R%0d", VECS[i].req),
                  {rgn_base, mem_sel, grp_idx, dev_addr, rf_addr},
                  {VECS[i].e_rgn, VECS[i].e_msel, VECS[i].e_grp, VECS[i].e_dev, VECS[i].e_rf});
            check("R12", sc_operand, {12'd0, VECS[i].sc});
        end

        // R2: index change is seen without a clock edge
        rf_index = 4'hA;
        #0.5;
        check("R2", rf_addr, 8'h3A);

        // R12: operand follows constant combinationally
        sc_field = 4'hC;
        #0.5;
        check("R12", sc_operand, 16'h000C);

        // R11: group strobe leaves other registers untouched
        @(negedge clk);
        ld = 9'b000000100;
        sc_field = 4'h3;
        @(posedge clk);
        #1;
        ld = '0;
        check("R11", {rgn_base, mem_sel, dev_addr}, {4'h3, 5'h06, 8'h80});
        check("R6", grp_idx, 2'd3);

        // R7 with new group: {0,11,00}
        ld = 9'b000010000;
        sc_field = 4'h4;
        @(posedge clk);
        #1;
        ld = '0;
        check("R7", mem_sel, 5'h0C);

        // R1 reset mid-run with a strobe present
        rst = 1'b1;
        ld = 9'b100000010;
        bus_word = 16'hFFFF;
        @(posedge clk);
        #1;
        ld = '0;
        check("R1", {rgn_base, mem_sel, grp_idx, dev_addr}, '0);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule